// File: doc/BRIEF.md
# Chainable Parallel-to-Serial Line Status Register

This block keeps a row of status cells, one per monitored line, and lets an external controller read them out one bit at a time. While the mode select input is high the block is in capture mode: every cell reloads its line status on each internal clock, and the serial output is held low. When the controller pulls mode select low, capture stops and the cells keep their last values. The highest cell then drives the serial output, and each rising edge of the external shift clock moves the contents one place towards the output. The serial data input fills the cell that is left empty.

Several blocks can share one shift clock and one mode select, with each serial output wired to the serial input of the next block. A single shift sequence then reads every block in turn from the serial output of the last one. The external mode select, shift clock and serial data input are asynchronous. Each passes through a two-stage synchroniser, and a shift is triggered by a rising edge seen on the synchronised shift clock.

A block reset is raised at once when either of two fault flags is active, or while the power-on reset is held. It clears the cells, forces the serial output low and is also brought out to the neighbouring filter logic. The block reset is released only after both flags have stayed clear for two internal clock edges.

Top module: `line_status_shifter`

## Requirements
- R1: While `par_sel` (synchronised) is 1, every cell reloads its `line_stat` bit on every internal clock, so the value present last before serial mode begins is the value captured.
- R2: While `par_sel` (synchronised) is 1, `ser_dout` is 0, even when the top cell `line_stat[CELLS-1]` holds 1.
- R3: While `par_sel` (synchronised) is 0, changes on `line_stat` have no effect. The cells keep the values captured last.
- R4: In serial mode `ser_dout` shows cell CELLS-1. Each rising edge of `ser_clk` moves cell i into cell i+1 and loads `ser_din` into cell 0, so bits leave in the order `line_stat[CELLS-1]` down to `line_stat[0]` and then the `ser_din` bits. The shift takes effect two internal clocks after the edge is synchronised.
- R5: After CELLS shifts with `ser_din` held at 0, `ser_dout` reads 0 on every further shift.
- R6: When two blocks share `ser_clk` and `par_sel`, and the first block's `ser_dout` drives the second block's `ser_din`, the second block's `ser_dout` produces all of its own bits, then all of the first block's bits, then the first block's `ser_din` bits.
- R7: When `uv_flag` or `ot_flag` is 1, `blk_reset` is 1 and `ser_dout` is 0 at once, with no clock needed. The cells are cleared to 0 at the next internal clock.
- R8: `blk_reset` falls at the second internal clock edge after both fault flags are 0, or after `rst_n` has been released, and not before.
- R9: Holding `ser_clk` high for many internal clocks produces exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| uv_flag | input | 1 | Supply-low fault flag, active high |
| ot_flag | input | 1 | Over-temperature fault flag, active high |
| line_stat | input | CELLS | Filtered line status bits, one per cell |
| par_sel | input | 1 | Mode select: 1 = capture (parallel), 0 = serial read-out |
| ser_clk | input | 1 | External shift clock, asynchronous |
| ser_din | input | 1 | Serial data input from the previous block in a chain |
| ser_dout | output | 1 | Serial data output, cell CELLS-1 gated by mode and reset |
| blk_reset | output | 1 | Block reset, also sent to the line filters |

## Verification
A wrong cell value shows up on `ser_dout` only when its bit reaches the head of the register. A cell that is frozen wrongly, or that missed a load, therefore appears after as many shifts as it sits from the top cell, and later still in a chain. A broken edge detector or a wrong mode gate shows within a few internal clocks of the next `ser_clk` edge, either as a skipped or doubled bit or as a non-zero output in capture mode. A reset release timer that is off by one shows on `blk_reset` on the exact edge where it should fall, so the bench samples that edge and the edge before it.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic {
    MODE_SERIAL  = 1'b0,
    MODE_CAPTURE = 1'b1
  } op_mode_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned HOLD_EDGES_DEF  = 2;
endpackage

// File: rtl/lss_sync.sv
module lss_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= INIT;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= INIT;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lss_rstgen.sv
module lss_rstgen #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_flag,
  input  logic ot_flag,
  output logic core_rst
);
  logic            fault;
  logic [HOLD-1:0] hold_q;

  assign fault = uv_flag | ot_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '1;
    else if (fault) hold_q <= '1;
    else            hold_q <= hold_q << 1;
  end

  assign core_rst = fault | (|hold_q);

  // R8: release only after the flags stayed clear across an edge
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> (!fault && $past(!fault)));

  // R8: a fault seen at an edge keeps the reset up at the next one
  p_fault_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> core_rst);
endmodule

// File: rtl/lss_cells.sv
module lss_cells #(
  parameter int unsigned CELLS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load_en,
  input  logic             shift_en,
  input  logic [CELLS-1:0] par_d,
  input  logic             din,
  output logic             head
);
  logic [CELLS-1:0] q;

  function automatic logic [CELLS-1:0] step(input logic [CELLS-1:0] v, input logic b);
    return {v[CELLS-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (clr)      q <= '0;
    else if (load_en)  q <= par_d;
    else if (shift_en) q <= step(q, din);
  end

  assign head = q[CELLS-1];

  // R1: capture loads the status word
  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !clr) |=> (q == $past(par_d)));

  // R3: serial mode with no shift keeps the cells
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !shift_en && !clr) |=> $stable(q));

  // R4: one shift moves every cell up and takes din at the bottom
  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en && !clr) |=> (q == {$past(q[CELLS-2:0]), $past(din)}));

  // R7: block reset empties the register
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
endmodule

// File: rtl/line_status_shifter.sv
module line_status_shifter
  import lss_pkg::*;
#(
  parameter int unsigned CELLS       = 8,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned HOLD_EDGES  = HOLD_EDGES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uv_flag,
  input  logic             ot_flag,
  input  logic [CELLS-1:0] line_stat,
  input  logic             par_sel,
  input  logic             ser_clk,
  input  logic             ser_din,
  output logic             ser_dout,
  output logic             blk_reset
);
  localparam int unsigned NSYNC = 3;
  localparam logic [NSYNC-1:0] SYNC_INIT = {MODE_CAPTURE, 1'b0, 1'b0};

  logic [NSYNC-1:0] sync_q;
  op_mode_e         mode_s;
  logic             sclk_s, sclk_d, din_s;
  logic             shift_pulse, load_en, core_rst, head;

  lss_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({par_sel, ser_clk, ser_din}),
    .q    (sync_q)
  );

  assign mode_s = op_mode_e'(sync_q[2]);
  assign sclk_s = sync_q[1];
  assign din_s  = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  // named internal events for assertions
  assign load_en     = (mode_s == MODE_CAPTURE);
  assign shift_pulse = sclk_s & ~sclk_d & (mode_s == MODE_SERIAL);

  lss_rstgen #(.HOLD(HOLD_EDGES)) u_rstgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .uv_flag (uv_flag),
    .ot_flag (ot_flag),
    .core_rst(core_rst)
  );

  lss_cells #(.CELLS(CELLS)) u_cells (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (core_rst),
    .load_en (load_en),
    .shift_en(shift_pulse),
    .par_d   (line_stat),
    .din     (din_s),
    .head    (head)
  );

  assign ser_dout  = head & ~load_en & ~core_rst;
  assign blk_reset = core_rst;

  // R9: a held shift clock yields a single shift event
  p_shift_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> !shift_pulse);

  // R2: output stays low for a full capture interval
  p_capture_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && $past(load_en)) |-> !ser_dout);
endmodule

// File: tb/test_line_status_shifter.sv
`timescale 1ns/1ps
module test_line_status_shifter;
  localparam int CELLS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv = 1'b0, ot = 1'b0;
  logic [CELLS-1:0] stat_a = '0, stat_b = '0;
  logic par_sel = 1'b1, sclk = 1'b0, din = 1'b0;
  logic dout_a, dout_b, brst_a, brst_b;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [2*CELLS-1:0] m;

  always #10 clk = ~clk;

  // head of chain
  line_status_shifter #(.CELLS(CELLS)) i_line_status_shifter_head (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv), .ot_flag(ot),
    .line_stat(stat_a), .par_sel(par_sel), .ser_clk(sclk), .ser_din(din),
    .ser_dout(dout_a), .blk_reset(brst_a));

  // last in chain, read by the bench
  line_status_shifter #(.CELLS(CELLS)) i_line_status_shifter (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv), .ot_flag(ot),
    .line_stat(stat_b), .par_sel(par_sel), .ser_clk(sclk), .ser_din(dout_a),
    .ser_dout(dout_b), .blk_reset(brst_b));

  function automatic logic [2*CELLS-1:0] chain_next(input logic [2*CELLS-1:0] v, input logic b);
    logic [2*CELLS-1:0] r;
    r = v << 1;
    r[0] = b;
    return r;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_chain(input string req);
    chk(req, dout_b, m[2*CELLS-1]);
    chk(req, dout_a, m[CELLS-1]);
  endtask

  task automatic shift1(input logic b, input string req);
    din = b;
    sclk = 1'b1;
    wait_clk(4);
    sclk = 1'b0;
    wait_clk(4);
    m = chain_next(m, b);
    check_chain(req);
  endtask

  // capture a fresh pair of words, enter serial mode, then scramble inputs
  task automatic capture(input logic [CELLS-1:0] a, input logic [CELLS-1:0] b);
    par_sel = 1'b1;
    stat_a = ~a;
    stat_b = ~b;
    wait_clk(3);
    stat_a = a;
    stat_b = b;
    wait_clk(4);
    chk("R2 capture mode output low", dout_b, 1'b0);
    chk("R2 capture mode output low", dout_a, 1'b0);
    m = {b, a};
    par_sel = 1'b0;
    wait_clk(4);
    stat_a = $urandom;
    stat_b = $urandom;
    wait_clk(2);
    check_chain("R1 R3 first bit after capture");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // reset state
    wait_clk(2);
    chk("R8 reset state blk_reset", brst_b, 1'b1);
    chk("R2 reset state output", dout_b, 1'b0);
    rst_n = 1'b1;
    wait_clk(1);
    chk("R8 held one edge after rst_n", brst_b, 1'b1);
    wait_clk(1);
    chk("R8 released on second edge", brst_b, 1'b0);

    // R2: top cell at 1 but capture mode
    stat_b = '1;
    wait_clk(6);
    chk("R2 top cell one in capture mode", dout_b, 1'b0);

    // directed: known pattern with zeros shifted in (R5, R6)
    capture(8'hA5, 8'hC3);
    for (int i = 0; i < 2 * CELLS + 8; i++) begin
      shift1(1'b0, "R4 R5 R6 zero fill");
      if (i >= CELLS - 1) chk("R5 head empty after eight shifts", dout_a, 1'b0);
    end

    // R9: held shift clock gives one shift
    capture(8'h6B, 8'h9E);
    din = 1'b1;
    sclk = 1'b1;
    wait_clk(12);
    m = chain_next(m, 1'b1);
    check_chain("R9 held clock single shift");
    sclk = 1'b0;
    wait_clk(4);
    check_chain("R9 after release still single shift");

    // R7/R8: undervoltage in serial mode
    capture(8'hFF, 8'hFF);
    uv = 1'b1;
    #1;
    chk("R7 uv raises blk_reset", brst_b, 1'b1);
    chk("R7 uv blocks output", dout_b, 1'b0);
    wait_clk(3);
    uv = 1'b0;
    wait_clk(1);
    chk("R8 still in reset after one edge", brst_b, 1'b1);
    chk("R7 output blocked during release", dout_b, 1'b0);
    wait_clk(1);
    chk("R8 released after two edges", brst_b, 1'b0);
    m = '0;
    check_chain("R7 cells cleared");
    for (int i = 0; i < CELLS; i++) shift1(1'b1, "R7 cleared data shifts out");

    // R7: overtemperature alone
    capture(8'h81, 8'h18);
    ot = 1'b1;
    #1;
    chk("R7 ot raises blk_reset", brst_a, 1'b1);
    chk("R7 ot blocks output", dout_a, 1'b0);
    wait_clk(2);
    ot = 1'b0;
    wait_clk(3);
    m = '0;
    check_chain("R7 ot cleared cells");

    // random sessions
    for (int s = 0; s < 20; s++) begin
      capture($urandom, $urandom);
      for (int i = 0; i < 2 * CELLS + 2; i++)
        shift1(1'($urandom), "R4 R6 random chain read");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule